// File: doc/BRIEF.md
# Triplicated Instruction Memory with Voted Background Scrubbing

This block holds a program in three identical memory copies and returns a single instruction for each fetch address. All three copies are read at the same time. A bitwise majority vote chooses the instruction that is returned, so a fault in any one copy stays hidden from the consumer. The fetch port only reads and has no path that writes to memory. Each copy also has a per-copy mismatch flag that shows which copy disagrees with the vote, for test visibility.

A background scrubber uses a second port on every copy. It reads all three copies at one address, votes the three words, and writes the voted word back into every copy in the following cycle. This removes a latent upset before a second upset can accumulate at the same word. The scrubber's own state is kept three times: three controllers, three address counters and three phase bits. Every controller computes its next state from the voted counter and the voted phase, and each controller drives the write enable of its own copy only. A scrub write never goes to the address that the fetch port is reading in that cycle. The memory models are behavioural, have computed initial contents, and include a fault-injection hook that flips chosen bits in one copy.

Top module: `tmr_scrub_rom`

## Requirements
- R1: While reset is asserted and right after it is released, `instr_o` is 0, `mismatch_o` is 0 and `scrub_addr_o` is 0.
- R2: The instruction for address a appears on `instr_o` one clock after a is presented on `fetch_addr_i`. Its value is the low DW bits of (a*40503) XOR 0x5A5A5A5A, which is the initial content of every copy.
- R3: When exactly one copy holds a corrupted word at address a, a fetch of a still returns the uncorrupted R2 value.
- R4: Bit k of `mismatch_o` (k = 0, 1, 2) is 1 when the word that copy k returned for the current fetch differs from `instr_o`, and 0 otherwise. It is valid in the same cycle as `instr_o`.
- R5: When `inj_en_i` is 1 at a clock edge, copy `inj_copy_i` (0, 1 or 2) at address `inj_addr_i` is XORed with `inj_mask_i`. The other copies are left unchanged.
- R6: While `scrub_en_i` is 1 and no conflict occurs, `scrub_addr_o` increases by one every two clock cycles and never changes on two consecutive edges. It wraps from 2^AW-1 to 0.
- R7: No scrub write goes to the address on `fetch_addr_i` in the same cycle. While they are equal, the write waits and `scrub_addr_o` holds. Once they differ, the write takes place and `scrub_addr_o` advances at the next edge.
- R8: After one full scrub pass, every copy holds the voted word at every address, so all of `mismatch_o` reads 0 when each address is fetched.
- R9: While `scrub_en_i` is 0, `scrub_addr_o` holds and no copy is rewritten, so an injected fault persists and its mismatch bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| fetch_addr_i | input | AW | Fetch address |
| instr_o | output | DW | Voted instruction, one cycle after the fetch address |
| mismatch_o | output | 3 | Per-copy disagreement with the vote, bit k for copy k |
| scrub_en_i | input | 1 | Enables background scrubbing |
| scrub_addr_o | output | AW | Voted scrub address counter |
| inj_en_i | input | 1 | Fault-injection strobe |
| inj_copy_i | input | 2 | Target copy for injection (0 to 2) |
| inj_addr_i | input | AW | Target address for injection |
| inj_mask_i | input | DW | Bits to flip in the target word |

## Verification
A wrong scrub phase or counter shows on `scrub_addr_o` within two cycles: a step skipped, a step taken twice in a row, or a stall with no collision. A scrub write to the wrong data, the wrong address or the wrong copy stays hidden behind the vote. It becomes visible as a mismatch bit, or as a wrong `instr_o` once a second copy is hit, on the first fetch of that word after one scrub pass. The bench sweeps every address and every copy with injected faults, so any such corruption is seen within one pass of 2^AW steps.

// File: rtl/tmr_rom_pkg.sv
package tmr_rom_pkg;
  // Initial program word for an address; memory copies and bench share the formula.
  function automatic logic [31:0] seed_word(input int unsigned addr);
    logic [31:0] prod;
    prod = addr * 32'd40503;
    return prod ^ 32'h5A5A5A5A;
  endfunction
endpackage

// File: rtl/maj_voter.sv
module maj_voter #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    y_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  end
endmodule

// File: rtl/rom_copy.sv
module rom_copy
  import tmr_rom_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] fetch_addr_i,
  output logic [DW-1:0] fetch_data_o,
  input  logic [AW-1:0] b_addr_i,
  input  logic          b_rd_en_i,
  input  logic          b_we_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o,
  input  logic          inj_en_i,
  input  logic [AW-1:0] inj_addr_i,
  input  logic [DW-1:0] inj_mask_i
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Behavioural model: program contents present at power-up.
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DW'(seed_word(i));
    end
  end

  // Second port writes; the fault hook takes priority.
  always_ff @(posedge clk_i) begin
    if (inj_en_i) begin
      mem[inj_addr_i] <= mem[inj_addr_i] ^ inj_mask_i;
    end else if (b_we_i) begin
      mem[b_addr_i] <= b_wdata_i;
    end
  end

  // Fetch port: read-only, registered output.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_data_o <= '0;
    end else begin
      fetch_data_o <= mem[fetch_addr_i];
    end
  end

  // Second-port read data, captured only on a scrub read.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_rdata_o <= '0;
    end else if (b_rd_en_i) begin
      b_rdata_o <= mem[b_addr_i];
    end
  end

  AST_NO_FETCH_COLLISION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_we_i |-> (b_addr_i != fetch_addr_i)); // R7
endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic [AW-1:0] addr_v_i,
  input  logic          phase_v_i,
  output logic [AW-1:0] addr_o,
  output logic          phase_o,
  output logic          rd_en_o,
  output logic          we_o
);
  // phase 0: read all copies; phase 1: write voted word back
  logic [AW-1:0] addr_d;
  logic          phase_d;

  always_comb begin
    addr_d  = addr_v_i;
    phase_d = 1'b0;
    rd_en_o = 1'b0;
    we_o    = 1'b0;
    if (en_i) begin
      if (!phase_v_i) begin
        rd_en_o = 1'b1;
        phase_d = 1'b1;
      end else if (fetch_addr_i != addr_v_i) begin
        we_o    = 1'b1;
        addr_d  = addr_v_i + 1'b1;
        phase_d = 1'b0;
      end else begin
        phase_d = 1'b1;   // postpone: fetch is reading this word
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      phase_o <= 1'b0;
    end else begin
      addr_o  <= addr_d;
      phase_o <= phase_d;
    end
  end
endmodule

// File: rtl/tmr_scrub_rom.sv
module tmr_scrub_rom #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] fetch_addr_i,
  output logic [DW-1:0] instr_o,
  output logic [2:0]    mismatch_o,
  input  logic          scrub_en_i,
  output logic [AW-1:0] scrub_addr_o,
  input  logic          inj_en_i,
  input  logic [1:0]    inj_copy_i,
  input  logic [AW-1:0] inj_addr_i,
  input  logic [DW-1:0] inj_mask_i
);
  localparam int NCOPY = 3;

  logic [DW-1:0] fetch_data [NCOPY];
  logic [DW-1:0] b_rdata    [NCOPY];
  logic [AW-1:0] cnt_q      [NCOPY];
  logic [NCOPY-1:0] phase_q;
  logic [NCOPY-1:0] rd_en;
  logic [NCOPY-1:0] we;
  logic [AW-1:0] addr_v;
  logic          phase_v;
  logic [DW-1:0] scrub_wdata;

  maj_voter #(.W(AW)) u_addr_vote (
    .a_i(cnt_q[0]), .b_i(cnt_q[1]), .c_i(cnt_q[2]), .y_o(addr_v));
  maj_voter #(.W(1)) u_phase_vote (
    .a_i(phase_q[0]), .b_i(phase_q[1]), .c_i(phase_q[2]), .y_o(phase_v));
  maj_voter #(.W(DW)) u_data_vote (
    .a_i(b_rdata[0]), .b_i(b_rdata[1]), .c_i(b_rdata[2]), .y_o(scrub_wdata));
  maj_voter #(.W(DW)) u_fetch_vote (
    .a_i(fetch_data[0]), .b_i(fetch_data[1]), .c_i(fetch_data[2]), .y_o(instr_o));

  for (genvar k = 0; k < NCOPY; k++) begin : g_copy
    logic inj_sel;
    always_comb begin
      inj_sel = inj_en_i && (inj_copy_i == 2'(k));
    end

    scrub_ctrl #(.AW(AW)) u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (scrub_en_i),
      .fetch_addr_i(fetch_addr_i),
      .addr_v_i    (addr_v),
      .phase_v_i   (phase_v),
      .addr_o      (cnt_q[k]),
      .phase_o     (phase_q[k]),
      .rd_en_o     (rd_en[k]),
      .we_o        (we[k])
    );

    rom_copy #(.AW(AW), .DW(DW)) u_mem (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fetch_addr_i(fetch_addr_i),
      .fetch_data_o(fetch_data[k]),
      .b_addr_i    (addr_v),
      .b_rd_en_i   (rd_en[k]),
      .b_we_i      (we[k]),
      .b_wdata_i   (scrub_wdata),
      .b_rdata_o   (b_rdata[k]),
      .inj_en_i    (inj_sel),
      .inj_addr_i  (inj_addr_i),
      .inj_mask_i  (inj_mask_i)
    );

    always_comb begin
      mismatch_o[k] = (fetch_data[k] != instr_o);
    end
  end

  always_comb begin
    scrub_addr_o = addr_v;
  end

  AST_SCRUB_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scrub_addr_o) |-> (scrub_addr_o == AW'($past(scrub_addr_o) + 1'b1))); // R6
  AST_SCRUB_HALF_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scrub_addr_o) |=> $stable(scrub_addr_o)); // R6
  AST_SCRUB_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scrub_en_i |=> $stable(scrub_addr_o)); // R9
  AST_WAIT_ON_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scrub_en_i && fetch_addr_i == scrub_addr_o) |=> $stable(scrub_addr_o)); // R7
endmodule

// File: tb/tmr_scrub_rom_tb_top.sv
module tmr_scrub_rom_tb_top;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic [DW-1:0] instr;
  logic [2:0]    mism;
  logic          scrub_en = 1'b0;
  logic [AW-1:0] scrub_addr;
  logic          inj_en = 1'b0;
  logic [1:0]    inj_copy = '0;
  logic [AW-1:0] inj_addr = '0;
  logic [DW-1:0] inj_mask = '0;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tmr_scrub_rom #(.AW(AW), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fetch_addr_i(fetch_addr), .instr_o(instr),
    .mismatch_o(mism), .scrub_en_i(scrub_en), .scrub_addr_o(scrub_addr),
    .inj_en_i(inj_en), .inj_copy_i(inj_copy), .inj_addr_i(inj_addr),
    .inj_mask_i(inj_mask));

  function automatic logic [DW-1:0] exp_word(input int a);
    logic [31:0] p;
    p = a * 32'd40503;
    return DW'(p ^ 32'h5A5A5A5A);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic inject(input int cp, input int a, input logic [DW-1:0] m);
    inj_en = 1'b1; inj_copy = 2'(cp); inj_addr = AW'(a); inj_mask = m;
    step();
    inj_en = 1'b0;
  endtask

  task automatic fetch_check(input int a, input string req, input logic [2:0] exp_m);
    fetch_addr = AW'(a);
    step();
    check(req, 32'(instr), 32'(exp_word(a)));
    check(req, 32'(mism), 32'(exp_m));
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int prev;
    int changes;
    int wraps;
    int hold;
    // R1 reset state
    step();
    check("R1 instr", 32'(instr), 0);
    check("R1 mismatch", 32'(mism), 0);
    check("R1 scrub_addr", 32'(scrub_addr), 0);
    step();
    rst_n = 1'b1;
    check("R1 after release", 32'(scrub_addr), 0);

    // R2 exhaustive fetch sweep
    for (int a = 0; a < DEPTH; a++) fetch_check(a, "R2 fetch", 3'b000);

    // R3 R4 R5 R9: every copy at every address, scrub disabled
    for (int cp = 0; cp < 3; cp++) begin
      for (int a = 0; a < DEPTH; a++) begin
        logic [DW-1:0] m;
        m = DW'(16'h0001 << ((a + cp) % DW)) | DW'(16'h8000 >> cp);
        hold = scrub_addr;
        inject(cp, a, m);
        fetch_check(a, "R3 R4 R5 masked fault", 3'(1 << cp));
        step();
        check("R9 still faulty", 32'(mism), 32'(1 << cp));
        check("R9 scrub_addr holds", 32'(scrub_addr), 32'(hold));
        inject(cp, a, m);
        fetch_check(a, "R5 fault undone", 3'b000);
      end
    end

    // R6 rate and wrap; fetch stays away from scrub address
    scrub_en = 1'b1;
    prev = scrub_addr; changes = 0; wraps = 0;
    for (int c = 0; c < 4 * DEPTH; c++) begin
      fetch_addr = scrub_addr + AW'(DEPTH / 2);
      step();
      if (scrub_addr != prev) begin
        changes++;
        check("R6 step by one", 32'(scrub_addr), 32'((prev + 1) % DEPTH));
        if (scrub_addr == 0) wraps++;
      end
      prev = scrub_addr;
    end
    check("R6 half rate count", 32'(changes), 32'(2 * DEPTH));
    check("R6 wrapped twice", 32'(wraps), 2);

    // R7 collision postpones write
    scrub_en = 1'b0;
    step();
    hold = scrub_addr;
    fetch_addr = AW'(hold);
    scrub_en = 1'b1;
    for (int c = 0; c < 8; c++) step();
    check("R7 held on collision", 32'(scrub_addr), 32'(hold));
    fetch_addr = AW'(hold) + AW'(DEPTH / 2);
    step();
    check("R7 advance after release", 32'(scrub_addr), 32'((hold + 1) % DEPTH));

    // R8 repair after a full pass
    scrub_en = 1'b0;
    step();
    inject(1, 5, 16'h0F0F);
    inject(2, 9, 16'h8001);
    inject(0, 12, 16'hFFFF);
    fetch_check(5, "R8 pre-scrub fault seen", 3'b010);
    scrub_en = 1'b1;
    for (int c = 0; c < 2 * DEPTH + 8; c++) begin
      fetch_addr = scrub_addr + AW'(DEPTH / 2);
      step();
    end
    scrub_en = 1'b0;
    step();
    for (int a = 0; a < DEPTH; a++) fetch_check(a, "R8 repaired", 3'b000);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule